// File: doc/BRIEF.md
# TLB Invalidation Sweep Engine

This block clears the presence flag of translation entries that satisfy a selectable predicate. It works through an entry array made of a set-associative region (`WAYS` ways of `ROWS` rows, entry index `way*ROWS + row`) followed by a fully-associative region of `FA_N` entries. A command is accepted on a valid/ready handshake. The engine then presents one entry index per clock on `ent_sel`/`ent_idx` and reads that entry's fields back in the same cycle. It asserts `ent_clr` in the cycles where the presence flag of the selected entry must be cleared. The array owner performs the write at the next rising edge.

The command carries an opcode, an ASID operand, a global-value operand, a virtual address, an index and the page size shared by the set-associative region. All of these are captured at acceptance, so they may change freely during a sweep. When the sweep ends, `done` pulses for one cycle. The surrounding logic uses that pulse as the request to flush any downstream translation cache. `cmd_ready` is low for the whole sweep, so a requester holding `cmd_valid` simply waits. No command is lost and none is accepted twice.

Top module: `tlbinv_sweep`

## Requirements
- R1: `cmd_ready` is high whenever no sweep is running and low in every cycle in which `ent_sel` is high; a command is taken at a rising edge where `cmd_valid` and `cmd_ready` are both high, and changes to the command inputs after that edge do not alter the sweep.
- R2: A sweep visits one entry per cycle in consecutive cycles, beginning in the cycle after acceptance; `done` is high for exactly one cycle, the cycle after the last visit, and `ent_clr` is high only in cycles where `ent_sel` is high.
- R3: Opcode 0 visits every entry index from 0 upward and clears each one.
- R4: Opcode 1 visits every entry and clears those whose global flag equals `cmd_g`.
- R5: Opcode 2 visits every entry and clears those that are not global and whose ASID equals `cmd_asid`.
- R6: An entry page-matches when `cmd_va >> (ps+1)` equals `ent_vppn >> (ps+1-13)`, where `ps` is `ent_ps` for indices at or above `WAYS*ROWS` and the captured `shared_ps` below it (ps is at least 12).
- R7: Opcode 3 visits every entry and clears present, non-global entries with an ASID match and a page match; `ent_clr` is never high for an entry whose presence flag is 0.
- R8: Opcode 4 visits every entry and clears present entries that page-match and are either global or have an ASID match.
- R9: Opcode 5 with `cmd_idx < WAYS*ROWS` visits, in increasing order, the `WAYS` entries `way*ROWS + (cmd_idx % ROWS)`; with `cmd_idx` inside the fully-associative region it visits all of that region in increasing order; in both cases it clears only non-global entries whose ASID equals `cmd_asid`.
- R10: Opcode 6 visits the same entries as opcode 5 for the same index and clears every visited entry.
- R11: Opcode 5 or 6 with `cmd_idx` at or beyond `WAYS*ROWS + FA_N`, and opcode 7 for any index, visit nothing and raise `done` in the cycle after acceptance.
- R12: After reset `cmd_ready` is high and `done`, `ent_sel` and `ent_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Operation code (0..7) |
| cmd_asid | input | ASID_W | ASID operand; also the owning ASID for opcode 5 |
| cmd_g | input | 1 | Global value compared by opcode 1 |
| cmd_va | input | VA_W | Virtual address for page operations |
| cmd_idx | input | IDX_W+1 | Entry index for row operations, IDX_W = clog2(WAYS*ROWS+FA_N) |
| shared_ps | input | PS_W | Page size of the set-associative region |
| ent_sel | output | 1 | An entry is being visited this cycle |
| ent_idx | output | IDX_W | Index of the visited entry |
| ent_exists | input | 1 | Presence flag of the visited entry |
| ent_g | input | 1 | Global flag of the visited entry |
| ent_asid | input | ASID_W | ASID of the visited entry |
| ent_vppn | input | VA_W-13 | Stored virtual page-pair number (address bits from 13 up) |
| ent_ps | input | PS_W | Stored page size of the visited entry |
| ent_clr | output | 1 | Clear the presence flag of the visited entry at the next edge |
| done | output | 1 | One-cycle end-of-sweep pulse and downstream flush request |

## Verification
The hardest case to reach is a page compare whose outcome depends on which page size applies. The stored VPPN has to differ from the address only in the bits that one size ignores and the other compares, and entry sizes have to disagree with the shared size. The bench therefore derives every stored VPPN from the command address with small flips at address bits 13, 14 and 19. It gives the set-associative entries stored sizes that must be ignored, and it runs each page opcode under two shared sizes. Row operations are swept over every index of a small configuration and past its end, so every row, the region boundary and the out-of-range case are each reached.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  typedef enum logic [2:0] {
    OP_ALL       = 3'd0,
    OP_GLB       = 3'd1,
    OP_ASID      = 3'd2,
    OP_PG_ASID   = 3'd3,
    OP_PG_ANY    = 3'd4,
    OP_ROW_CLR   = 3'd5,
    OP_ROW_FLUSH = 3'd6,
    OP_NONE      = 3'd7
  } inv_op_e;
endpackage

// File: rtl/tlbinv_seq.sv
module tlbinv_seq
  import tlbinv_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int WAYS = 8,
  parameter int FA_N = 64,
  localparam int SA_N  = WAYS * ROWS,
  localparam int TOTAL = SA_N + FA_N,
  localparam int IDX_W = $clog2(TOTAL),
  localparam int CNT_W = $clog2(TOTAL + 1),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  inv_op_e          op,
  input  logic [IDX_W:0]   idx,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic             done
);
  localparam logic [IDX_W:0] SA_LIM  = (IDX_W+1)'(SA_N);
  localparam logic [IDX_W:0] TOT_LIM = (IDX_W+1)'(TOTAL);

  logic [IDX_W-1:0] first, step, step_q;
  logic [CNT_W-1:0] cnt, rem_q;

  // Visit plan: first index, stride and number of entries
  always_comb begin
    first = '0;
    step  = IDX_W'(1);
    cnt   = '0;
    case (op)
      OP_ROW_CLR, OP_ROW_FLUSH: begin
        if (idx < SA_LIM) begin
          first = IDX_W'(idx[ROW_W-1:0]);
          step  = IDX_W'(ROWS);
          cnt   = CNT_W'(WAYS);
        end else if (idx < TOT_LIM) begin
          first = IDX_W'(SA_N);
          cnt   = CNT_W'(FA_N);
        end
      end
      OP_NONE: cnt = '0;
      default: cnt = CNT_W'(TOTAL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cur_idx <= '0;
      rem_q   <= '0;
      step_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (cnt == '0) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          cur_idx <= first;
          step_q  <= step;
          rem_q   <= cnt - CNT_W'(1);
        end
      end else if (busy) begin
        if (rem_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cur_idx <= cur_idx + step_q;
          rem_q   <= rem_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int ASID_W   = 10,
  parameter int VA_W     = 48,
  parameter int PS_W     = 6,
  parameter int VPPN_LSB = 13,
  localparam int VPPN_W  = VA_W - VPPN_LSB
) (
  input  inv_op_e           op,
  input  logic [ASID_W-1:0] asid,
  input  logic              g_val,
  input  logic [VA_W-1:0]   va,
  input  logic [PS_W-1:0]   ps,
  input  logic              exists,
  input  logic              e_g,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VPPN_W-1:0] e_vppn,
  output logic              hit
);
  logic [VA_W-1:0] e_va, keep;
  logic [PS_W:0]   sh;
  logic            page_hit, own;

  assign e_va     = {e_vppn, {VPPN_LSB{1'b0}}};
  assign sh       = {1'b0, ps} + (PS_W+1)'(1);
  assign keep     = {VA_W{1'b1}} << sh;
  assign page_hit = ((va ^ e_va) & keep) == '0;
  assign own      = (e_asid == asid);

  always_comb begin
    case (op)
      OP_ALL, OP_ROW_FLUSH: hit = 1'b1;
      OP_GLB:               hit = (e_g == g_val);
      OP_ASID, OP_ROW_CLR:  hit = !e_g && own;
      OP_PG_ASID:           hit = exists && !e_g && own && page_hit;
      OP_PG_ANY:            hit = exists && (e_g || own) && page_hit;
      default:              hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbinv_sweep.sv
module tlbinv_sweep
  import tlbinv_pkg::*;
#(
  parameter int ROWS     = 256,
  parameter int WAYS     = 8,
  parameter int FA_N     = 64,
  parameter int ASID_W   = 10,
  parameter int VA_W     = 48,
  parameter int PS_W     = 6,
  localparam int VPPN_LSB = 13,
  localparam int SA_N    = WAYS * ROWS,
  localparam int TOTAL   = SA_N + FA_N,
  localparam int IDX_W   = $clog2(TOTAL),
  localparam int VPPN_W  = VA_W - VPPN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic              cmd_g,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [IDX_W:0]    cmd_idx,
  input  logic [PS_W-1:0]   shared_ps,
  output logic              ent_sel,
  output logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_exists,
  input  logic              ent_g,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VPPN_W-1:0] ent_vppn,
  input  logic [PS_W-1:0]   ent_ps,
  output logic              ent_clr,
  output logic              done
);
  localparam logic [IDX_W-1:0] FA_BASE = IDX_W'(SA_N);

  inv_op_e           op_q;
  logic [ASID_W-1:0] asid_q;
  logic              g_q;
  logic [VA_W-1:0]   va_q;
  logic [PS_W-1:0]   sps_q, eff_ps;
  logic              accept, busy, hit;

  assign accept = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      asid_q <= '0;
      g_q    <= 1'b0;
      va_q   <= '0;
      sps_q  <= '0;
    end else if (accept) begin
      op_q   <= inv_op_e'(cmd_op);
      asid_q <= cmd_asid;
      g_q    <= cmd_g;
      va_q   <= cmd_va;
      sps_q  <= shared_ps;
    end
  end

  tlbinv_seq #(.ROWS(ROWS), .WAYS(WAYS), .FA_N(FA_N)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .op      (inv_op_e'(cmd_op)),
    .idx     (cmd_idx),
    .busy    (busy),
    .cur_idx (ent_idx),
    .done    (done)
  );

  assign eff_ps = (ent_idx >= FA_BASE) ? ent_ps : sps_q;

  tlbinv_match #(.ASID_W(ASID_W), .VA_W(VA_W), .PS_W(PS_W), .VPPN_LSB(VPPN_LSB)) u_match (
    .op     (op_q),
    .asid   (asid_q),
    .g_val  (g_q),
    .va     (va_q),
    .ps     (eff_ps),
    .exists (ent_exists),
    .e_g    (ent_g),
    .e_asid (ent_asid),
    .e_vppn (ent_vppn),
    .hit    (hit)
  );

  assign cmd_ready = !busy;
  assign ent_sel   = busy;
  assign ent_clr   = busy && hit;
endmodule

// File: rtl/tlbinv_sweep_chk.sv
module tlbinv_sweep_chk #(
  parameter int ROWS = 256,
  parameter int WAYS = 8,
  parameter int FA_N = 64,
  localparam int SA_N  = WAYS * ROWS,
  localparam int TOTAL = SA_N + FA_N,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ent_sel,
  input logic [IDX_W-1:0] ent_idx,
  input logic             ent_clr,
  input logic             ent_exists,
  input logic             done,
  input logic [2:0]       op_q
);
  localparam logic [IDX_W:0] SA_LIM  = (IDX_W+1)'(SA_N);
  localparam logic [IDX_W:0] TOT_LIM = (IDX_W+1)'(TOTAL);

  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ent_sel) |-> done);

  a_r2_clr_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    ent_clr |-> ent_sel);

  a_r7_skip_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_clr && (op_q == 3'd3 || op_q == 3'd4)) |-> ent_exists);

  a_r9_row_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_sel && $past(ent_sel) && (op_q == 3'd5 || op_q == 3'd6) && ({1'b0, ent_idx} < SA_LIM))
      |-> (ent_idx == $past(ent_idx) + IDX_W'(ROWS)));

  a_r11_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ent_sel |-> ({1'b0, ent_idx} < TOT_LIM));
endmodule

bind tlbinv_sweep tlbinv_sweep_chk #(.ROWS(ROWS), .WAYS(WAYS), .FA_N(FA_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ent_sel    (ent_sel),
  .ent_idx    (ent_idx),
  .ent_clr    (ent_clr),
  .ent_exists (ent_exists),
  .done       (done),
  .op_q       (op_q)
);

// File: tb/tlbinv_sweep_tb.sv
module tlbinv_sweep_tb;
  localparam int ROWS = 4, WAYS = 8, FA_N = 8, ASID_W = 4, VA_W = 24, PS_W = 5;
  localparam int SA_N = WAYS * ROWS, TOTAL = SA_N + FA_N;
  localparam int IDX_W = $clog2(TOTAL);

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic              cmd_valid = 0, cmd_ready, cmd_g = 0;
  logic [2:0]        cmd_op = 0;
  logic [ASID_W-1:0] cmd_asid = 0;
  logic [VA_W-1:0]   cmd_va = 0;
  logic [IDX_W:0]    cmd_idx = 0;
  logic [PS_W-1:0]   shared_ps = 12;
  logic              ent_sel, ent_clr, done;
  logic [IDX_W-1:0]  ent_idx;
  logic              ent_exists, ent_g;
  logic [ASID_W-1:0] ent_asid;
  logic [VA_W-14:0]  ent_vppn;
  logic [PS_W-1:0]   ent_ps;

  bit              ex[TOTAL], ex0[TOTAL], gb[TOTAL];
  logic [ASID_W-1:0] as_[TOTAL];
  logic [VA_W-14:0]  vp[TOTAL];
  logic [PS_W-1:0]   ps_[TOTAL];
  int ev[64], vs[64];
  int ev_n, vs_n;
  int checks = 0, errors = 0, cyc = 0;
  int unsigned s = 32'h1234_5678;

  tlbinv_sweep #(.ROWS(ROWS), .WAYS(WAYS), .FA_N(FA_N), .ASID_W(ASID_W), .VA_W(VA_W), .PS_W(PS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_asid(cmd_asid), .cmd_g(cmd_g), .cmd_va(cmd_va), .cmd_idx(cmd_idx), .shared_ps(shared_ps),
    .ent_sel(ent_sel), .ent_idx(ent_idx), .ent_exists(ent_exists), .ent_g(ent_g),
    .ent_asid(ent_asid), .ent_vppn(ent_vppn), .ent_ps(ent_ps), .ent_clr(ent_clr), .done(done));

  wire in_rng = int'(ent_idx) < TOTAL;
  assign ent_exists = in_rng ? ex[ent_idx] : 1'b0;
  assign ent_g      = in_rng ? gb[ent_idx] : 1'b0;
  assign ent_asid   = in_rng ? as_[ent_idx] : '0;
  assign ent_vppn   = in_rng ? vp[ent_idx] : '0;
  assign ent_ps     = in_rng ? ps_[ent_idx] : '0;

  always @(posedge clk) if (ent_clr && in_rng) ex[ent_idx] <= 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function int unsigned nxt();
    s = s * 1664525 + 1013904223;
    return s >> 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int va);
    for (int i = 0; i < TOTAL; i++) begin
      int unsigned r = nxt();
      int fl;
      ex[i]  = (r % 4) != 0;
      gb[i]  = ((r >> 3) % 4) == 0;
      as_[i] = ASID_W'((r >> 6) % 4);
      ps_[i] = PS_W'(12 + (r >> 9) % 4);
      case ((r >> 12) % 8)
        1: fl = 1; 2: fl = 2; 3: fl = 3; 4: fl = 64; 6: fl = 2;
        default: fl = 0;
      endcase
      vp[i] = (VA_W-13)'((va >> 13) ^ fl);
    end
  endtask

  function automatic bit epred(int op, int i, int asid, bit g, int va, int sps);
    int ps = (i >= SA_N) ? int'(ps_[i]) : sps;
    bit pg = ((va >> (ps + 1)) == (int'(vp[i]) >> (ps + 1 - 13)));
    bit own = (int'(as_[i]) == asid);
    case (op)
      0, 6: return 1;
      1: return gb[i] == g;
      2, 5: return !gb[i] && own;
      3: return ex0[i] && !gb[i] && own && pg;
      4: return ex0[i] && (gb[i] || own) && pg;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int op, int idx);
    if (op == 7 || ((op == 5 || op == 6) && idx >= TOTAL)) return "R11";
    case (op)
      0: return "R3"; 1: return "R4"; 2: return "R5";
      3: return "R7 R6"; 4: return "R8 R6"; 5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input int op, input int asid, input bit g, input int va, input int idx, input int sps);
    string t = tag_of(op, idx);
    bit gap = 0, rdy_bad = 0, empty_clr = 0, st_ok;
    int t0;
    ev_n = 0;
    if (op == 5 || op == 6) begin
      if (idx < SA_N) for (int w = 0; w < WAYS; w++) begin ev[ev_n] = w * ROWS + idx % ROWS; ev_n++; end
      else if (idx < TOTAL) for (int i = SA_N; i < TOTAL; i++) begin ev[ev_n] = i; ev_n++; end
    end else if (op != 7) begin
      for (int i = 0; i < TOTAL; i++) begin ev[ev_n] = i; ev_n++; end
    end
    for (int i = 0; i < TOTAL; i++) ex0[i] = ex[i];
    @(negedge clk);
    cmd_op = 3'(op); cmd_asid = ASID_W'(asid); cmd_g = g; cmd_va = VA_W'(va);
    cmd_idx = (IDX_W+1)'(idx); shared_ps = PS_W'(sps); cmd_valid = 1;
    chk(cmd_ready == 1'b1, "R1 ready when idle", int'(cmd_ready), 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_asid = ~cmd_asid; cmd_g = ~cmd_g; cmd_va = ~cmd_va;
    shared_ps = PS_W'(sps == 12 ? 13 : 12); cmd_op = 3'd0; cmd_idx = 0;
    vs_n = 0; t0 = cyc;
    while (!done && cyc - t0 < 200) begin
      if (ent_sel) begin
        if (vs_n < 64) vs[vs_n] = int'(ent_idx);
        vs_n++;
        if (cmd_ready) rdy_bad = 1;
        if (ent_clr && !ent_exists && (op == 3 || op == 4)) empty_clr = 1;
      end else gap = 1;
      @(negedge clk);
    end
    chk(done == 1'b1 && !ent_sel, {t, " R2 done after last visit"}, int'(done), 1);
    chk(!gap, {t, " R2 consecutive visits"}, int'(gap), 0);
    chk(!rdy_bad, "R1 ready low while sweeping", int'(rdy_bad), 0);
    st_ok = (vs_n == ev_n);
    for (int k = 0; k < ev_n && k < vs_n; k++) if (vs[k] != ev[k]) st_ok = 0;
    chk(st_ok, {t, " visit order"}, vs_n, ev_n);
    if (op == 3) chk(!empty_clr, "R7 no clear on absent entry", int'(empty_clr), 0);
    for (int i = 0; i < TOTAL; i++) begin
      bit vis = 0, e;
      for (int k = 0; k < ev_n; k++) if (ev[k] == i) vis = 1;
      e = ex0[i] && !(vis && epred(op, i, asid, g, va, sps));
      if (ex[i] != e) begin
        chk(0, {t, $sformatf(" presence of entry %0d", i)}, int'(ex[i]), int'(e));
        break;
      end
      if (i == TOTAL - 1) chk(1, t, 0, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: idle outputs after reset
    chk(cmd_ready == 1'b1, "R12 ready after reset", int'(cmd_ready), 1);
    chk(done == 1'b0, "R12 done after reset", int'(done), 0);
    chk(ent_sel == 1'b0 && ent_clr == 1'b0, "R12 no visit after reset", int'(ent_sel), 0);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && !done && !ent_sel, "R12 idle after release", int'(cmd_ready), 1);
    for (int op = 0; op < 5; op++) begin
      for (int k = 0; k < 8; k++) begin
        int va = int'(nxt() % (1 << VA_W));
        fill(va);
        run(op, k % 4, k[0], va, 0, 12 + (k / 2) % 2);
      end
    end
    for (int op = 5; op < 7; op++) begin
      for (int idx = 0; idx < TOTAL + 8; idx++) begin
        int va = int'(nxt() % (1 << VA_W));
        fill(va);
        run(op, idx % 4, 0, va, idx, 12);
      end
      fill(0);
      run(op, 1, 0, 0, (1 << (IDX_W + 1)) - 1, 12);
    end
    fill(5 << 13);
    run(7, 0, 0, 5 << 13, 0, 12);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule